// File: doc/BRIEF.md
# Line-Synchronized Pseudo-Random Pixel Generator

This block produces a stream of pseudo-random 16-bit pixel words for exercising a data link and its receiver. A 14-bit Fibonacci shift register with fixed feedback supplies the sequence. Its starting state comes from a programmable seed input, so a receiver-side checker can predict the stream.

Generation needs two enables, a global test-mode bit and a separate random-pattern enable. Setting both arms the block and captures the seed. Output begins only on the first rising edge of the line-sync input that arrives while the block is armed. From then on the register advances once per pixel clock, and the valid flag stays high. Clearing either enable stops the stream. A later re-enable captures the seed again and waits for a new line-sync edge.

Top module: `lsync_prbs_gen`

## Requirements
- R1: After a synchronous active-low reset, `pix_valid` is 0 and `pix_data` is all zeros.
- R2: With only one of `test_mode` and `prnd_en` set, `pix_valid` stays 0 and `pix_data` stays zero, whatever `lsync` does.
- R3: Once both enables are set, `pix_valid` and `pix_data` stay 0 until `lsync` is sampled high in a cycle after it was sampled low while armed. `pix_valid` rises on the clock edge that samples that rising edge.
- R4: The first valid word carries the captured seed in bits 15:2.
- R5: Each following cycle with `pix_valid` high advances the 14-bit state s to {s[12:0], s[13]^s[12]^s[10]^s[8]}, which is the polynomial x^14+x^13+x^11+x^9+1.
- R6: Bits 1:0 of `pix_data` are always 0.
- R7: A seed of zero is replaced by 1, so the first valid word is 16'h0004 and the state never becomes zero.
- R8: Clearing either enable while running makes `pix_valid` 0 and `pix_data` zero from the next clock edge.
- R9: The seed is captured in the cycle the block arms. Changes to `seed` after that have no effect until a re-enable, which captures the seed again and waits for a new `lsync` edge.
- R10: Rising edges of `lsync` while running neither restart nor disturb the sequence.
- R11: If `lsync` is already high when the block arms, it must fall and rise again before output starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsync | input | 1 | Line-start sync, synchronous to clk; its rising edge starts output |
| test_mode | input | 1 | Global test-mode enable |
| prnd_en | input | 1 | Pseudo-random pattern enable |
| seed | input | 14 | Starting state of the shift register |
| pix_data | output | 16 | Pixel word; state in bits 15:2, zeros elsewhere or when idle |
| pix_valid | output | 1 | High while the pseudo-random stream is running |

## Verification
The bench builds the block with its defaults: a 14-bit state, a 16-bit word and the tap mask 14'h3500. With these values the two zero pad bits below the state can be seen at the port. The bench's own model of the named polynomial is compared word by word over runs of several hundred steps. Because the state is only 14 bits wide, the zero-seed substitution and seeds with high bits set are easy to reach, and so is the ordering of arm, sync edge and disable.

// File: rtl/lsync_prbs_pkg.sv
// Package: shared types for the line-synchronized pseudo-random generator.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package lsync_prbs_pkg;

    // Control states: waiting for enables, armed for sync edge, streaming.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } prbs_state_e;

    // Default feedback mask: taps for x^14 + x^13 + x^11 + x^9 + 1.
    localparam logic [13:0] DEF_TAP_MASK = 14'h3500;

endpackage

// File: rtl/lsync_edge_det.sv
// Rising-edge detector for the line-sync input.
// Assumes lsync is already synchronous to clk. The history bit resets
// high, so a line that is high out of reset is not taken as an edge.
module lsync_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lsync_i,
    output logic rise_o
);

    logic prev_q;

    // Keep last sampled sync level, updated every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lsync_i;
    end

    // Edge is a high sample following a low one.
    assign rise_o = lsync_i & ~prev_q;

endmodule

// File: rtl/prbs_ctrl.sv
// Control sequencer: idle -> armed (seed load) -> run (step per cycle).
// Assumes en_i is the AND of both enables and rise_i is a sync edge.
module prbs_ctrl
    import lsync_prbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rise_i,
    output logic load_o,
    output logic step_o,
    output logic run_o
);

    prbs_state_e state_q;
    prbs_state_e state_d;

    // Next-state selection from enables and sync edge.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (en_i) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!en_i)       state_d = ST_IDLE;
                else if (rise_i) state_d = ST_RUN;
            end
            ST_RUN:   if (!en_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load_o = (state_q == ST_IDLE) && en_i;
    assign step_o = (state_q == ST_RUN) && en_i;
    assign run_o  = (state_q == ST_RUN);

endmodule

// File: rtl/prbs_lfsr.sv
// Fibonacci shift register with a parameter feedback mask.
// Loads a seed (zero replaced by 1) or shifts left one step, feedback
// entering at bit 0. Assumes load_i and step_i are never both high.
module prbs_lfsr #(
    parameter int               W    = 14,
    parameter logic [W-1:0]     MASK = 14'h3500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;
    logic [W-1:0] seed_fix;
    logic         fb;

    // Substitute a non-zero start so the register cannot lock up.
    assign seed_fix = (seed_i == '0) ? W'(1) : seed_i;
    // Parity of tapped bits forms the new low bit.
    assign fb = ^(state_q & MASK);

    // Load seed, or advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n)      state_q <= W'(1);
        else if (load_i) state_q <= seed_fix;
        else if (step_i) state_q <= {state_q[W-2:0], fb};
    end

    assign state_o = state_q;

endmodule

// File: rtl/lsync_prbs_gen.sv
// Top: line-synchronized pseudo-random pixel generator.
// Arms on both enables, starts on the next line-sync rising edge, then
// outputs one word per clock with the state placed in the upper bits.
// Assumes all inputs are synchronous to clk.
module lsync_prbs_gen #(
    parameter int                   STATE_W  = 14,
    parameter int                   OUT_W    = 16,
    parameter logic [STATE_W-1:0]   TAP_MASK = lsync_prbs_pkg::DEF_TAP_MASK
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lsync,
    input  logic               test_mode,
    input  logic               prnd_en,
    input  logic [STATE_W-1:0] seed,
    output logic [OUT_W-1:0]   pix_data,
    output logic               pix_valid
);

    localparam int PAD_W = OUT_W - STATE_W;

    logic               en;
    logic               rise;
    logic               load;
    logic               step;
    logic               run;
    logic [STATE_W-1:0] lfsr_q;

    // Both enables must be set for any activity.
    assign en = test_mode & prnd_en;

    lsync_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .lsync_i (lsync),
        .rise_o  (rise)
    );

    prbs_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .rise_i (rise),
        .load_o (load),
        .step_o (step),
        .run_o  (run)
    );

    prbs_lfsr #(
        .W    (STATE_W),
        .MASK (TAP_MASK)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .seed_i  (seed),
        .state_o (lfsr_q)
    );

    // Word formatting: state in the top bits, zero pad below, zero when idle.
    generate
        if (PAD_W > 0) begin : g_pad
            assign pix_data = run ? {lfsr_q, {PAD_W{1'b0}}} : '0;
        end else begin : g_trunc
            assign pix_data = run ? lfsr_q[STATE_W-1 -: OUT_W] : '0;
        end
    endgenerate

    assign pix_valid = run;

endmodule

// File: rtl/lsync_prbs_chk.sv
// Checker: port-level properties of the pseudo-random generator.
// Assumes OUT_W >= STATE_W so the state occupies the top word bits.
module lsync_prbs_chk #(
    parameter int                 STATE_W  = 14,
    parameter int                 OUT_W    = 16,
    parameter logic [STATE_W-1:0] TAP_MASK = 14'h3500
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lsync,
    input logic               test_mode,
    input logic               prnd_en,
    input logic [OUT_W-1:0]   pix_data,
    input logic               pix_valid
);

    // Expected successor of a word's state field.
    function automatic logic [STATE_W-1:0] succ(input logic [OUT_W-1:0] w);
        logic [STATE_W-1:0] s;
        s = w[OUT_W-1 -: STATE_W];
        return {s[STATE_W-2:0], ^(s & TAP_MASK)};
    endfunction

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!pix_valid && pix_data == '0));

    p_needs_both_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_mode || !prnd_en) |=> !pix_valid);

    p_start_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> ($past(lsync) && !$past(lsync, 2)));

    p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> pix_data == '0);

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid)) |->
            pix_data[OUT_W-1 -: STATE_W] == succ($past(pix_data)));

    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_data[OUT_W-1 -: STATE_W] != '0);

    p_disable_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !(test_mode && prnd_en)) |=> (!pix_valid && pix_data == '0));

endmodule

bind lsync_prbs_gen lsync_prbs_chk #(
    .STATE_W  (STATE_W),
    .OUT_W    (OUT_W),
    .TAP_MASK (TAP_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lsync     (lsync),
    .test_mode (test_mode),
    .prnd_en   (prnd_en),
    .pix_data  (pix_data),
    .pix_valid (pix_valid)
);

// File: tb/sim_lsync_prbs_gen.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_lsync_prbs_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lsync = 1'b0;
    logic        test_mode = 1'b0;
    logic        prnd_en = 1'b0;
    logic [13:0] seed = '0;
    logic [15:0] pix_data;
    logic        pix_valid;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [13:0] exp_st;

    always #10 clk = ~clk;

    lsync_prbs_gen #(
        .STATE_W  (14),
        .OUT_W    (16),
        .TAP_MASK (14'h3500)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .lsync     (lsync),
        .test_mode (test_mode),
        .prnd_en   (prnd_en),
        .seed      (seed),
        .pix_data  (pix_data),
        .pix_valid (pix_valid)
    );

    // Reference step for x^14 + x^13 + x^11 + x^9 + 1.
    function automatic logic [13:0] model_next(input logic [13:0] s);
        return {s[12:0], s[13] ^ s[12] ^ s[10] ^ s[8]};
    endfunction

    task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check the outputs show idle: valid low, data zero.
    task automatic chk_idle(input string req);
        chk(req, {pix_valid, pix_data}, 17'h0);
    endtask

    // Compare n running words against the model, advancing exp_st.
    task automatic run_words(input string req, input int n, input bit toggle_sync);
        for (int i = 0; i < n; i++) begin
            chk(req, {pix_valid, pix_data}, {1'b1, exp_st, 2'b00});
            exp_st = model_next(exp_st);
            if (toggle_sync) lsync = i[2];
            @(negedge clk);
        end
        lsync = 1'b0;
    endtask

    // One-cycle sync pulse; returns at the negedge where output has started.
    task automatic pulse_sync();
        lsync = 1'b1;
        @(negedge clk);
        lsync = 1'b0;
    endtask

    task automatic stop_all();
        test_mode = 1'b0;
        prnd_en   = 1'b0;
        lsync     = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset release");
    endtask

    task automatic t_single_enable();
        seed = 14'h0123;
        test_mode = 1'b1;
        @(negedge clk);
        pulse_sync();
        repeat (2) @(negedge clk);
        chk_idle("R2 test_mode only");
        test_mode = 1'b0;
        prnd_en = 1'b1;
        @(negedge clk);
        pulse_sync();
        @(negedge clk);
        chk_idle("R2 prnd_en only");
        stop_all();
    endtask

    task automatic t_basic();
        seed = 14'h1ACE;
        test_mode = 1'b1;
        prnd_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk_idle("R3 armed waiting for sync");
        end
        pulse_sync();
        exp_st = 14'h1ACE;
        chk(pix_data[15:2] == 14'h1ACE ? "R4 first word is seed" : "R4 first word is seed",
            {pix_valid, pix_data}, {1'b1, 14'h1ACE, 2'b00});
        chk("R6 low bits zero", {15'h0, pix_data[1:0]}, 17'h0);
        run_words("R5 sequence", 300, 1'b0);
    endtask

    task automatic t_disable_mode();
        test_mode = 1'b0;
        @(negedge clk);
        chk_idle("R8 test_mode cleared");
        stop_all();
    endtask

    task automatic t_zero_seed();
        seed = 14'h0000;
        test_mode = 1'b1;
        prnd_en = 1'b1;
        repeat (2) @(negedge clk);
        pulse_sync();
        chk("R7 zero seed replaced", {pix_valid, pix_data}, {1'b1, 16'h0004});
        exp_st = 14'h0001;
        run_words("R7 sequence from 1", 40, 1'b0);
        prnd_en = 1'b0;
        @(negedge clk);
        chk_idle("R8 prnd_en cleared");
        stop_all();
    endtask

    task automatic t_rearm();
        seed = 14'h2F0F;
        test_mode = 1'b1;
        prnd_en = 1'b1;
        @(negedge clk);
        seed = 14'h0555;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_idle("R9 rearmed waits for sync");
        end
        pulse_sync();
        exp_st = 14'h2F0F;
        run_words("R9 captured seed used", 30, 1'b0);
        chk("R9 late seed ignored", {3'b0, pix_data[15:2]}, {3'b0, exp_st});
    endtask

    task automatic t_sync_while_running();
        run_words("R10 sync edges while running", 64, 1'b1);
        stop_all();
    endtask

    task automatic t_sync_high();
        seed = 14'h3FFF;
        lsync = 1'b1;
        @(negedge clk);
        test_mode = 1'b1;
        prnd_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk_idle("R11 held-high sync no start");
        end
        lsync = 1'b0;
        @(negedge clk);
        chk_idle("R11 sync low still waiting");
        pulse_sync();
        exp_st = 14'h3FFF;
        run_words("R11 start after new edge", 20, 1'b0);
        stop_all();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_enable();
        t_basic();
        t_disable_mode();
        t_zero_seed();
        t_rearm();
        t_sync_while_running();
        t_sync_high();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule